// File: doc/BRIEF.md
# Push-Button Debouncer with Fixed Filter Window

This block turns the raw level of a single active-low push-button into a clean level that is 1 while the key is held and 0 while it is released. The pin is first passed through a register synchroniser. Two register pairs then compare each new sample with the one before it. One pair produces a single-cycle pulse when the key goes down and the other produces one when the key comes up.

A power-up settling counter keeps both pulses blocked for a fixed time after reset. Once that time has passed, the block arms itself and stays armed until the next reset. A case-based state machine waits in a selection state for a pulse. A press pulse sends it down a press path and a release pulse sends it down a release path. On either path it runs a filter window: a prescaler makes a 1 ms tick and a millisecond counter counts the ticks. When the window ends, the output takes the new level and the machine returns to the selection state with both counters cleared. Any pulse that arrives while a window is running is dropped.

The clock rate is a parameter, and the settling time and the millisecond length are derived from it. A bench can therefore use a slow clock and get short windows.

Top module: `btn_settle`

## Requirements
- R1: While reset is asserted and directly after it, `key_held` is 0.
- R2: For the first SETTLE_US microseconds after reset, key transitions are ignored. After that time the block is armed and it stays armed until the next reset.
- R3: A key-down transition drives `key_held` to 1. This happens on exactly the (4 + WINDOW_MS·CLK_HZ/1000)-th rising clock edge, counting from the first edge that samples the low pin. The count is made up of the synchroniser, the edge register, the state register and the window.
- R4: A key-up transition drives `key_held` to 0 with the same latency as R3.
- R5: Each internal press or release pulse lasts exactly one clock cycle.
- R6: Pin transitions that occur while a filter window is running have no effect. The output still changes at the time set by the first transition, and a release inside a press window leaves the output at 1 afterwards.
- R7: A key-down transition while `key_held` is already 1 runs a press window and leaves the output at 1.
- R8: The millisecond counter never exceeds WINDOW_MS − 1. Both counters are 0 whenever the machine is in its selection state.
- R9: `key_held` changes only on the edge that ends a window. It rises only at the end of a press path and falls only at the end of a release path.
- R10: While the pin holds a steady level and no window is running, `key_held` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_n_raw | input | 1 | Raw button pin, 0 while pressed |
| key_held | output | 1 | Debounced level, 1 while held |

## Verification
The checker assumes that reset is held for at least one clock edge. It also assumes that the pin is a plain binary level with no unknown value once reset is released. The pulse checks hold however the pin moves, because the edge registers can only produce isolated pulses. The bench changes the pin only on falling clock edges so that every sampling edge is unambiguous. Bounces are placed early in a window, so the last edge pulse always falls inside the running window and can never arrive after the window has closed.

// File: rtl/btn_settle_pkg.sv
package btn_settle_pkg;
   typedef enum logic [1:0] {
      ST_SELECT  = 2'd0,
      ST_PRESS   = 2'd1,
      ST_RELEASE = 2'd2
   } flt_state_t;
endpackage

// File: rtl/btn_edge_front.sv
module btn_edge_front #(
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_CYC  = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall_pulse,
   output logic rise_pulse,
   output logic armed
);
   localparam int CW = $clog2(SETTLE_CYC + 1);

   logic [SYNC_STAGES-1:0] chain;
   logic                   synced;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= pin_n;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign synced = chain[SYNC_STAGES-1];

   // down-going pair idles high, up-going pair idles low
   logic dn_cur, dn_prev, up_cur, up_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dn_cur  <= 1'b1;
         dn_prev <= 1'b1;
         up_cur  <= 1'b0;
         up_prev <= 1'b0;
      end else begin
         dn_cur  <= synced;
         dn_prev <= dn_cur;
         up_cur  <= synced;
         up_prev <= up_cur;
      end
   end

   // power-up settling gate, sticky once set
   logic [CW-1:0] settle_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         settle_cnt <= '0;
         armed      <= 1'b0;
      end else if (!armed) begin
         if (settle_cnt == CW'(SETTLE_CYC - 1)) armed <= 1'b1;
         else                                   settle_cnt <= settle_cnt + 1'b1;
      end
   end

   assign fall_pulse = armed & ~dn_cur & dn_prev;
   assign rise_pulse = armed & up_cur & ~up_prev;
endmodule

// File: rtl/btn_window_fsm.sv
module btn_window_fsm
   import btn_settle_pkg::*;
#(
   parameter int MS_CYC    = 50000,
   parameter int WINDOW_MS = 10
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           fall_pulse,
   input  logic                           rise_pulse,
   output logic                           level,
   output flt_state_t                     state,
   output logic [$clog2(MS_CYC)-1:0]      pre_cnt,
   output logic [$clog2(WINDOW_MS+1)-1:0] ms_cnt
);
   localparam int PW = $clog2(MS_CYC);
   localparam int MW = $clog2(WINDOW_MS + 1);

   generate
      if (MS_CYC < 2)    begin : g_bad_ms  $error("MS_CYC must be at least 2");    end
      if (WINDOW_MS < 1) begin : g_bad_win $error("WINDOW_MS must be at least 1"); end
   endgenerate

   logic count_en, tick, last;
   assign count_en = (state != ST_SELECT);
   assign tick     = count_en && (pre_cnt == PW'(MS_CYC - 1));
   assign last     = tick && (ms_cnt == MW'(WINDOW_MS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_SELECT;
         pre_cnt <= '0;
         ms_cnt  <= '0;
         level   <= 1'b0;
      end else begin
         case (state)
            ST_SELECT: begin
               pre_cnt <= '0;
               ms_cnt  <= '0;
               if (fall_pulse)      state <= ST_PRESS;
               else if (rise_pulse) state <= ST_RELEASE;
            end
            ST_PRESS, ST_RELEASE: begin
               if (last) begin
                  level   <= (state == ST_PRESS);
                  state   <= ST_SELECT;
                  pre_cnt <= '0;
                  ms_cnt  <= '0;
               end else if (tick) begin
                  pre_cnt <= '0;
                  ms_cnt  <= ms_cnt + 1'b1;
               end else begin
                  pre_cnt <= pre_cnt + 1'b1;
               end
            end
            default: state <= ST_SELECT;
         endcase
      end
   end
endmodule

// File: rtl/btn_settle.sv
module btn_settle
   import btn_settle_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int SETTLE_US   = 100,
   parameter int WINDOW_MS   = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_n_raw,
   output logic key_held
);
   localparam int MS_CYC     = CLK_HZ / 1000;
   localparam int SETTLE_CYC = (MS_CYC * SETTLE_US) / 1000;
   localparam int PW         = $clog2(MS_CYC);
   localparam int MW         = $clog2(WINDOW_MS + 1);

   generate
      if (CLK_HZ < 2000)  begin : g_bad_clk    $error("CLK_HZ too low for 1 ms tick"); end
      if (SETTLE_CYC < 1) begin : g_bad_settle $error("settling time rounds to zero"); end
   endgenerate

   logic       fall_pulse, rise_pulse, armed;
   flt_state_t state;
   logic [PW-1:0] pre_cnt;
   logic [MW-1:0] ms_cnt;

   btn_edge_front #(
      .SYNC_STAGES (SYNC_STAGES),
      .SETTLE_CYC  (SETTLE_CYC)
   ) u_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_n      (key_n_raw),
      .fall_pulse (fall_pulse),
      .rise_pulse (rise_pulse),
      .armed      (armed)
   );

   btn_window_fsm #(
      .MS_CYC    (MS_CYC),
      .WINDOW_MS (WINDOW_MS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .fall_pulse (fall_pulse),
      .rise_pulse (rise_pulse),
      .level      (key_held),
      .state      (state),
      .pre_cnt    (pre_cnt),
      .ms_cnt     (ms_cnt)
   );
endmodule

// File: rtl/btn_settle_chk.sv
module btn_settle_chk
   import btn_settle_pkg::*;
#(
   parameter int PW        = 16,
   parameter int MW        = 4,
   parameter int WINDOW_MS = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fall_pulse,
   input logic          rise_pulse,
   input logic          armed,
   input flt_state_t    state,
   input logic [PW-1:0] pre_cnt,
   input logic [MW-1:0] ms_cnt,
   input logic          key_held
);
   assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fall_pulse |=> !fall_pulse);
   assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |=> !rise_pulse);
   assert_armed_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);
   assert_unarmed_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> (state == ST_SELECT));
   assert_ms_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ms_cnt < MW'(WINDOW_MS));
   assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SELECT) |-> (pre_cnt == '0 && ms_cnt == '0));
   assert_change_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(key_held) |-> ($past(state) != ST_SELECT && state == ST_SELECT));
   assert_rise_press_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_held) |-> ($past(state) == ST_PRESS));
   assert_fall_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(key_held) |-> ($past(state) == ST_RELEASE));
   assert_lockout_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PRESS && ms_cnt != MW'(WINDOW_MS - 1)) |=> (state == ST_PRESS));
endmodule

bind btn_settle btn_settle_chk #(
   .PW        (PW),
   .MW        (MW),
   .WINDOW_MS (WINDOW_MS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fall_pulse (fall_pulse),
   .rise_pulse (rise_pulse),
   .armed      (armed),
   .state      (state),
   .pre_cnt    (pre_cnt),
   .ms_cnt     (ms_cnt),
   .key_held   (key_held)
);

// File: tb/btn_settle_bench.sv
module btn_settle_bench;
   localparam int PERIOD    = 10;
   localparam int CLK_HZ    = 100_000;
   localparam int WINDOW_MS = 10;
   localparam int MS        = CLK_HZ / 1000;
   localparam int LAT       = 4 + WINDOW_MS * MS;

   typedef struct packed {
      logic        pin;
      logic [15:0] cyc;
      logic        exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 16'd20,        1'b0, 4'd10}, // R10 idle steady
      '{1'b0, 16'(LAT - 1),  1'b0, 4'd3},  // R3 one edge early
      '{1'b0, 16'd1,         1'b1, 4'd3},  // R3 exact edge
      '{1'b0, 16'd300,       1'b1, 4'd10}, // R10 held steady
      '{1'b1, 16'(LAT - 1),  1'b1, 4'd4},  // R4 one edge early
      '{1'b1, 16'd1,         1'b0, 4'd4},  // R4 exact edge
      '{1'b0, 16'd2,         1'b0, 4'd6},  // R6 press with bounce
      '{1'b1, 16'd3,         1'b0, 4'd6},
      '{1'b0, 16'(LAT - 6),  1'b0, 4'd6},
      '{1'b0, 16'd1,         1'b1, 4'd6},
      '{1'b1, 16'd1,         1'b1, 4'd6},  // R6 release with bounce
      '{1'b0, 16'd1,         1'b1, 4'd6},
      '{1'b1, 16'(LAT - 3),  1'b1, 4'd6},
      '{1'b1, 16'd1,         1'b0, 4'd6}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic key_n_raw = 1'b1;
   logic key_held;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #(PERIOD / 2) clk = ~clk;

   btn_settle #(
      .CLK_HZ    (CLK_HZ),
      .SETTLE_US (100),
      .WINDOW_MS (WINDOW_MS)
   ) u_btn_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_n_raw (key_n_raw),
      .key_held  (key_held)
   );

   task automatic check(input string tag, input logic exp);
      checks++;
      if (key_held !== exp) begin
         errors++;
         $display("FAIL %s key_held actual %b expected %b at %0t", tag, key_held, exp, $time);
      end
   endtask

   task automatic drive_wait(input logic pin, input int cyc);
      @(negedge clk);
      key_n_raw = pin;
      repeat (cyc) @(posedge clk);
      #1;
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 in reset", 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      check("R1 after reset", 1'b0);
      drive_wait(1'b1, 30);

      for (int i = 0; i < NV; i++) begin
         drive_wait(VEC[i].pin, int'(VEC[i].cyc));
         check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
      end

      // R6: release inside a press window is dropped, output stays held
      drive_wait(1'b1, 200);
      drive_wait(1'b0, 500);
      drive_wait(1'b1, LAT - 501);
      check("R6 before end", 1'b0);
      drive_wait(1'b1, 1);
      check("R6 window end", 1'b1);
      drive_wait(1'b1, 2000);
      check("R6 R10 stale release ignored", 1'b1);

      // R7: press while already held
      drive_wait(1'b0, LAT);
      check("R7 re-press held", 1'b1);
      drive_wait(1'b1, LAT);
      check("R4 R8 release after re-press", 1'b0);

      // R2: reset mid-window, pin low during settling is ignored
      drive_wait(1'b0, 500);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 async reset clears", 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (LAT + 200) @(posedge clk);
      #1;
      check("R2 settling press ignored", 1'b0);
      drive_wait(1'b1, LAT);
      check("R2 R9 release path keeps low", 1'b0);
      drive_wait(1'b0, LAT);
      check("R2 R5 armed press", 1'b1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule